// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM

This block is a synchronous single-port memory whose shared data path can switch between reads and writes on consecutive clocks without inserting a dead cycle. Every command input is captured on the rising clock edge. A read returns its word through an output register two edges after its address was taken. A write supplies its data two edges after its address, so both directions have the same pipeline depth and can be interleaved freely.

Between the address capture and the array update, a write sits in a late-write buffer. A read that reaches the output stage while an older write to the same word is still in that buffer receives the buffered bytes merged with the array bytes. Each byte lane is eight data bits plus an optional parity bit and has its own active-low write strobe. Three further inputs control the block:
- A stall input freezes the whole pipeline.
- An asynchronous output enable gates the returned data.
- A sleep input blocks new commands after a two-cycle lag and forces the data output undriven for as long as it is high.

Command entry is a valid-only stream: `cmd_valid` marks a command, and there is no ready. The block never applies back-pressure. The only hold is `stall`, which the owner drives and which also freezes read results in place.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted on a rising edge only when `cmd_valid` is high, `stall` is low and the sleep gate of R6 is open. A cycle with `cmd_valid` low changes neither the memory nor the outputs, whatever the other command inputs carry.
- R2: A read accepted on edge N loads its word into the output register on edge N+2. `rd_valid` is high in the cycle that follows that edge, and reads and writes may alternate on every edge with no idle cycle.
- R3: The write data for a write accepted on edge N is sampled from `wdata` on edge N+2, that is on the second non-stalled edge after acceptance. Once the write is complete, later reads of that word return it.
- R4: Lane l occupies bits [l*LANE_W +: LANE_W], where LANE_W = 8 + PAR_BITS. `cmd_wen_n[l]` = 0 writes lane l and `cmd_wen_n[l]` = 1 leaves it unchanged. A write with every strobe high is an abort and changes nothing.
- R5: While `stall` is high, no command is accepted and no register changes: pipeline, late-write buffer, array, `rd_valid` and the output word all hold.
- R6: A command is ignored on edge N if `sleep` was high when sampled on edge N-2. Commands are accepted again once `sleep` has been low at edge N-2. Commands already in flight complete. While `sleep` is high, `dq_drive` is low.
- R7: `out_en` acts without a clock. While it is low, `dq_drive` is low and `rdata` reads zero even when `rd_valid` is high.
- R8: A read whose word has a pending write in the late-write buffer returns, per lane, the buffered bytes for the strobed lanes and the array bytes for the others. The result equals program-order memory contents.
- R9: `dq_drive` = `rd_valid` and `out_en` and not `sleep`. `rdata` shows the output word only while `dq_drive` is high and reads zero otherwise.
- R10: After reset `rd_valid`, `dq_drive` and `rdata` are zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | High freezes every register and blocks commands |
| sleep | input | 1 | Low-power request: gates commands after two edges, hides data at once |
| out_en | input | 1 | Asynchronous data output enable |
| cmd_valid | input | 1 | A command is presented |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wen_n | input | LANES | Active-low per-lane write strobes |
| wdata | input | LANES*(8+PAR_BITS) | Write data, sampled two edges after its address |
| rdata | output | LANES*(8+PAR_BITS) | Read data while driven, zero otherwise |
| rd_valid | output | 1 | Output register holds a read result |
| dq_drive | output | 1 | Read data is being driven onto the bus |

## Verification
Several properties are checked on every cycle:
- a stall freezes the output register and `rd_valid`;
- once sleep has been high two edges earlier, no command is accepted;
- sleep or a low output enable keeps the bus undriven, and an undriven bus reads zero;
- an unstalled read always surfaces three sampling edges later.

Only the bench scenarios can show data correctness: merging through the late-write buffer, partial and aborted strobes, write data taken on the correct late edge, and memory left untouched by invalid cycles and blocked commands. These scenarios compare against a program-order memory model.

// File: rtl/zt_pkg.sv
package zt_pkg;
  typedef enum logic [1:0] {
    ZT_IDLE  = 2'd0,
    ZT_READ  = 2'd1,
    ZT_WRITE = 2'd2
  } zt_op_e;
endpackage

// File: rtl/zt_cmd_pipe.sv
// Command capture: sleep gate plus a fixed-depth address/control pipeline.
module zt_cmd_pipe
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int LANES     = 2,
  parameter int SLEEP_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              sleep,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_wen_n,
  output logic              accept,
  output zt_op_e            p_op,
  output logic [ADDR_W-1:0] p_addr,
  output logic [LANES-1:0]  p_mask
);
  localparam int DEPTH = 2;

  logic [SLEEP_LAG-1:0] slp_q;
  zt_op_e               op_q   [DEPTH];
  logic [ADDR_W-1:0]    addr_q [DEPTH];
  logic [LANES-1:0]     mask_q [DEPTH];
  zt_op_e               new_op;

  // sleep takes SLEEP_LAG edges to close the command gate (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slp_q <= '0;
    else        slp_q <= {slp_q[SLEEP_LAG-2:0], sleep};
  end

  assign accept = cmd_valid && !stall && !slp_q[SLEEP_LAG-1];

  always_comb begin
    if (!accept)       new_op = ZT_IDLE;
    else if (cmd_write) new_op = ZT_WRITE;
    else               new_op = ZT_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        op_q[i]   <= ZT_IDLE;
        addr_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (!stall) begin
      op_q[0]   <= new_op;
      addr_q[0] <= cmd_addr;
      mask_q[0] <= cmd_write ? ~cmd_wen_n : '0;
      for (int i = 1; i < DEPTH; i++) begin
        op_q[i]   <= op_q[i-1];
        addr_q[i] <= addr_q[i-1];
        mask_q[i] <= mask_q[i-1];
      end
    end
  end

  assign p_op   = op_q[DEPTH-1];
  assign p_addr = addr_q[DEPTH-1];
  assign p_mask = mask_q[DEPTH-1];
endmodule

// File: rtl/zt_store.sv
// Array, late-write buffer with per-lane forwarding, and output register.
module zt_store
  import zt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  zt_op_e                  p_op,
  input  logic [ADDR_W-1:0]       p_addr,
  input  logic [LANES-1:0]        p_mask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_word,
  output logic                    rd_vld
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic              wb_vld;
  logic [ADDR_W-1:0] wb_addr;
  logic [LANES-1:0]  wb_mask;
  logic [DATA_W-1:0] wb_data;
  logic [DATA_W-1:0] arr_word;
  logic [DATA_W-1:0] merged;
  logic              wb_hit;

  assign arr_word = mem[p_addr];
  assign wb_hit   = wb_vld && (wb_addr == p_addr);

  // per-lane forwarding from the late-write buffer (R8)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (wb_hit && wb_mask[l]) ?
        wb_data[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
  end

  // buffered write retires into the array on the next advancing edge
  always_ff @(posedge clk) begin
    if (!stall && wb_vld) begin
      for (int l = 0; l < LANES; l++) begin
        if (wb_mask[l]) mem[wb_addr][l*LANE_W +: LANE_W] <= wb_data[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_vld  <= 1'b0;
      wb_addr <= '0;
      wb_mask <= '0;
      wb_data <= '0;
      rd_vld  <= 1'b0;
      rd_word <= '0;
    end else if (!stall) begin
      wb_vld  <= (p_op == ZT_WRITE) && (|p_mask);
      wb_addr <= p_addr;
      wb_mask <= p_mask;
      wb_data <= wdata;
      rd_vld  <= (p_op == ZT_READ);
      if (p_op == ZT_READ) rd_word <= merged;
    end
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int LANES    = 2,
  parameter int PAR_BITS = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             stall,
  input  logic                             sleep,
  input  logic                             out_en,
  input  logic                             cmd_valid,
  input  logic                             cmd_write,
  input  logic [ADDR_W-1:0]                cmd_addr,
  input  logic [LANES-1:0]                 cmd_wen_n,
  input  logic [LANES*(8+PAR_BITS)-1:0]    wdata,
  output logic [LANES*(8+PAR_BITS)-1:0]    rdata,
  output logic                             rd_valid,
  output logic                             dq_drive
);
  localparam int LANE_W = 8 + PAR_BITS;
  localparam int DATA_W = LANES * LANE_W;

  logic              accept;
  zt_op_e            p_op;
  logic [ADDR_W-1:0] p_addr;
  logic [LANES-1:0]  p_mask;
  logic [DATA_W-1:0] rd_word;
  logic              rv;

  zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .SLEEP_LAG(2)) u_pipe (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sleep(sleep),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wen_n(cmd_wen_n), .accept(accept), .p_op(p_op), .p_addr(p_addr),
    .p_mask(p_mask)
  );

  zt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .stall(stall), .p_op(p_op), .p_addr(p_addr),
    .p_mask(p_mask), .wdata(wdata), .rd_word(rd_word), .rd_vld(rv)
  );

  assign rd_valid = rv;
  assign dq_drive = rv && out_en && !sleep;
  assign rdata    = dq_drive ? rd_word : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              sleep,
  input logic              cmd_write,
  input logic              accept,
  input logic              rd_valid,
  input logic              dq_drive,
  input logic [DATA_W-1:0] rd_word,
  input logic [DATA_W-1:0] rdata
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && !cmd_write, 3) && !$past(stall, 2) && !$past(stall, 1)) |-> rd_valid);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(rd_valid) && $stable(rd_word)));

  assert_sleep_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep, 2) |-> !accept);

  assert_sleep_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_drive);

  assert_drive_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> rd_valid);

  assert_undriven_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_drive |-> (rdata == '0));
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .sleep(sleep), .cmd_write(cmd_write),
  .accept(accept), .rd_valid(rd_valid), .dq_drive(dq_drive), .rd_word(rd_word),
  .rdata(rdata)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0, sleep = 1'b0, out_en = 1'b1;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LN-1:0] cmd_wen_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rd_valid, dq_drive;

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .PAR_BITS(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sleep(sleep), .out_en(out_en),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wen_n(cmd_wen_n), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .dq_drive(dq_drive)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // program-order reference: memory, two pipeline slots, output slot, sleep history
  logic [DW-1:0] model [1<<AW];
  int            m1_op = 0, m2_op = 0;    // 0 idle, 1 read, 2 write
  logic [DW-1:0] m1_d = '0, m2_d = '0;
  bit            eo_v = 0;
  logic [DW-1:0] eo_d = '0;
  bit            h1 = 0, h2 = 0;

  function automatic logic [DW-1:0] fdat(int a, int k);
    return DW'((a * 4099 + k * 1237 + 77) & 32'h3FFFF);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit w, int a, logic [LN-1:0] s, logic [DW-1:0] d,
                      bit st, bit sl, bit oe);
    bit acc;
    logic [DW-1:0] cur;
    cmd_valid = v; cmd_write = w; cmd_addr = AW'(a); cmd_wen_n = s;
    stall = st; sleep = sl; out_en = oe;
    wdata = (m2_op == 2) ? m2_d : 18'h2A5A5;
    acc = v && !st && !h2;
    @(posedge clk);
    if (!st) begin
      eo_v = (m2_op == 1);
      if (m2_op == 1) eo_d = m2_d;
      m2_op = m1_op; m2_d = m1_d;
      m1_op = 0;
      if (acc && w) begin
        cur = model[a];
        for (int l = 0; l < LN; l++) if (!s[l]) cur[l*LW +: LW] = d[l*LW +: LW];
        model[a] = cur;
        m1_op = 2; m1_d = d;
      end else if (acc) begin
        m1_op = 1; m1_d = model[a];
      end
    end
    h2 = h1; h1 = sl;
    @(negedge clk);
    check("R9 rd_valid", {17'b0, rd_valid}, {17'b0, eo_v});
    check("R9 dq_drive", {17'b0, dq_drive}, {17'b0, eo_v && oe && !sl});
    check(cur_req, rdata, (eo_v && oe && !sl) ? eo_d : '0);
  endtask

  task automatic rd(int a);
    step(1, 0, a, '1, '0, 0, 0, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '1, '0, 0, 0, 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 rd_valid", {17'b0, rd_valid}, '0);
    check("R10 dq_drive", {17'b0, dq_drive}, '0);
    check("R10 rdata", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: fill every word back to back with full strobes
    cur_req = "R3";
    for (int a = 0; a < 16; a++) step(1, 1, a, 2'b00, fdat(a, 0), 0, 0, 1);
    // R2: read every word back to back, first read directly after last write
    cur_req = "R2";
    for (int a = 0; a < 16; a++) rd(a);
    idle(3);

    // R8 / R4: write then read the same word on the next edge, all strobe patterns
    cur_req = "R8";
    for (int i = 0; i < 32; i++) begin
      step(1, 1, i % 16, LN'(i % 4), fdat(i, 1), 0, 0, 1);
      rd(i % 16);
    end
    // read two edges after the write (array path after retirement)
    for (int i = 0; i < 16; i++) begin
      step(1, 1, i, LN'((i + 1) % 4), fdat(i, 2), 0, 0, 1);
      idle(1);
      rd(i);
    end
    idle(3);

    // R4: aborted write leaves the word intact
    cur_req = "R4";
    step(1, 1, 5, 2'b11, 18'h3FFFF, 0, 0, 1);
    idle(2);
    rd(5);
    step(1, 1, 6, 2'b10, 18'h00000, 0, 0, 1);
    rd(6);
    idle(3);

    // R5 / R1: stalls and invalid cycles mixed into traffic
    cur_req = "R5";
    for (int i = 0; i < 60; i++)
      step((i % 5) != 4, (i % 2) == 0, (i * 5) % 16, LN'(i % 3), fdat(i, 3),
           (i % 3) == 1, 0, 1);
    idle(3);
    cur_req = "R1";
    for (int a = 0; a < 16; a++) rd(a);
    idle(3);

    // R7: output enable toggling while reads stream
    cur_req = "R7";
    for (int i = 0; i < 12; i++) step(1, 0, i, '1, '0, 0, 0, (i % 2) == 1);
    idle(3);

    // R6: sleep window during a read stream, then writes during sleep are dropped
    cur_req = "R6";
    for (int i = 0; i < 14; i++) step(1, 0, i, '1, '0, 0, (i >= 3 && i < 8), 1);
    for (int i = 0; i < 6; i++) step(1, 1, i, 2'b00, 18'h0, 0, (i < 5), 1);
    idle(3);
    for (int a = 0; a < 6; a++) rd(a);
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule